// File: doc/BRIEF.md
# Per-Core Ordered Store Queue with Load Forwarding

This block sits between one core and one memory port and gives the core a total-store-order view of memory. Stores from the core go into a small queue and are written to memory later, one at a time and oldest first. A load first searches the queue: if one or more queued stores target its address, the youngest of them supplies the data at once. Otherwise the load goes to memory ahead of any queued stores, which is the only reordering the block allows.

A fence and an atomic swap both wait until the queue has drained. The swap then reads the old word and writes the new one with nothing else on the memory port in between, and returns the old word. The core port carries one request at a time. The block answers loads, fences and swaps on the response port. Stores receive no response.

The controller is a state machine with six states. `S_IDLE` accepts requests and owns nothing on the memory port except retirement of the head entry. A load that misses in the queue moves from `S_IDLE` to `S_LD_ISSUE`, which drives the read and moves to `S_LD_WAIT` when memory accepts it. `S_LD_WAIT` returns to `S_IDLE` on the memory response. An accepted swap moves from `S_IDLE` to `S_SW_READ`, then to `S_SW_WAIT` once the read is accepted, then to `S_SW_WRITE` on the read data, and back to `S_IDLE` once memory accepts the write. A load that hits in the queue and a fence both stay in `S_IDLE`.

Top module: `tso_store_queue`

## Requirements
- R1: A store (op code 1) is accepted into the queue and is not written to memory during the cycle in which it is accepted. While memory refuses writes, the memory contents stay unchanged and `sb_empty` is low.
- R2: Queued stores reach memory strictly oldest first, at most one per cycle. The head entry leaves only in a cycle where memory accepts the write.
- R3: A load (op code 0) whose word address matches queued stores returns the data of the youngest matching store. The response comes in the cycle after acceptance, and memory is not touched.
- R4: A load with no matching queued store reads memory and may finish while older stores to other addresses are still queued. While such a read is outstanding, only queue retirement writes use the memory port.
- R5: The queue holds DEPTH entries (8 by default). When it is full, `req_ready` is low for a store until an entry retires, while loads are still accepted.
- R6: A fence (op code 2) is accepted only when the queue is empty. Its response, with data 0, follows in the next cycle, and every earlier store is in memory by then.
- R7: An atomic swap (op code 3) is accepted only when the queue is empty. It then reads the addressed word and writes `req_wdata`, with no other memory access in between, and responds with the old word.
- R8: A load accepted in the same cycle that its matching store retires from the head returns the stored value. A load just after retirement reads the same value from memory.
- R9: A synchronous active-high reset empties the queue, returns the controller to `S_IDLE`, and leaves `mem_req_valid` and `rsp_valid` low.
- R10: Every accepted load, fence and swap produces exactly one one-cycle `rsp_valid` pulse. A store produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Core request accepted this cycle when valid |
| req_op | input | 2 | 0 load, 1 store, 2 fence, 3 swap |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store or swap data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DW | Load data, old swap data, or 0 for a fence |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | AW | Memory word address |
| mem_req_wdata | output | DW | Memory write data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | DW | Read data |
| sb_empty | output | 1 | Queue holds no entries |

## Verification
A queue hit and a fence respond in the first cycle after acceptance. A miss needs one cycle to issue the read, the memory model's one-cycle latency, and one more registered cycle. A swap adds a write beat after the read. The bench drives requests at falling edges and samples all outputs there, and it waits for `rsp_valid` with a bounded poll rather than a fixed count. The checks that tie timing to acceptance (the hit one cycle later, the load that coincides with retirement) rely on the exact falling edge after the accepting clock. A monitor at each rising edge compares every memory write with the oldest store still owed to memory.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_FENCE = 2'd2,
        OP_SWAP  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LD_ISSUE,
        S_LD_WAIT,
        S_SW_READ,
        S_SW_WAIT,
        S_SW_WRITE
    } state_e;
endpackage

// File: rtl/tsq_queue.sv
module tsq_queue #(
    parameter int DEPTH = 8,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic [AW-1:0] look_addr,
    output logic          hit,
    output logic [DW-1:0] hit_data,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          full,
    output logic          empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = PW + 1;

    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    logic [PW-1:0] head, tail;
    logic [CW-1:0] count;

    assign full      = (count == CW'(DEPTH));
    assign empty     = (count == '0);
    assign head_addr = addr_q[head];
    assign head_data = data_q[head];

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                addr_q[tail] <= push_addr;
                data_q[tail] <= push_data;
                tail         <= tail + 1'b1;
            end
            if (pop) head <= head + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Walk from oldest to youngest so that the last match wins.
    always_comb begin
        logic [PW-1:0] idx;
        hit      = 1'b0;
        hit_data = '0;
        idx      = head;
        for (int i = 0; i < DEPTH; i++) begin
            idx = head + PW'(i);
            if ((CW'(i) < count) && (addr_q[idx] == look_addr)) begin
                hit      = 1'b1;
                hit_data = data_q[idx];
            end
        end
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> (!full || pop));

    // R2
    retire_step_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> (count == $past(count) - 1'b1));

    // R2
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    // R9
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> empty);
endmodule

// File: rtl/tsq_ctrl.sv
module tsq_ctrl
    import tsq_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    input  logic          q_empty,
    input  logic          q_full,
    input  logic          q_hit,
    input  logic [DW-1:0] q_hit_data,
    input  logic [AW-1:0] head_addr,
    input  logic [DW-1:0] head_data,
    output logic          q_push,
    output logic          q_pop,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_rdata
);
    state_e        state, state_nx;
    op_e           op;
    logic          accept;
    logic [AW-1:0] addr_r;
    logic [DW-1:0] wdata_r;
    logic [DW-1:0] old_r;
    logic          port_owned;

    assign op = op_e'(req_op);

    always_comb begin
        req_ready = 1'b0;
        if (state == S_IDLE) begin
            unique case (op)
                OP_LOAD:  req_ready = 1'b1;
                OP_STORE: req_ready = !q_full;
                OP_FENCE: req_ready = q_empty;
                OP_SWAP:  req_ready = q_empty;
                default:  req_ready = 1'b0;
            endcase
        end
    end

    assign accept = req_valid && req_ready;
    assign q_push = accept && (op == OP_STORE);

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (accept && op == OP_LOAD && !q_hit) state_nx = S_LD_ISSUE;
                if (accept && op == OP_SWAP)           state_nx = S_SW_READ;
            end
            S_LD_ISSUE: if (mem_req_ready) state_nx = S_LD_WAIT;
            S_LD_WAIT:  if (mem_rsp_valid) state_nx = S_IDLE;
            S_SW_READ:  if (mem_req_ready) state_nx = S_SW_WAIT;
            S_SW_WAIT:  if (mem_rsp_valid) state_nx = S_SW_WRITE;
            S_SW_WRITE: if (mem_req_ready) state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    // Memory port: the controller takes it in its issue states, otherwise the head retires.
    always_comb begin
        port_owned    = 1'b1;
        mem_req_valid = 1'b1;
        mem_req_write = 1'b0;
        mem_req_addr  = addr_r;
        mem_req_wdata = wdata_r;
        unique case (state)
            S_LD_ISSUE, S_SW_READ: begin
                mem_req_write = 1'b0;
            end
            S_SW_WRITE: begin
                mem_req_write = 1'b1;
            end
            default: begin
                port_owned    = 1'b0;
                mem_req_valid = !q_empty;
                mem_req_write = 1'b1;
                mem_req_addr  = head_addr;
                mem_req_wdata = head_data;
            end
        endcase
        q_pop = !port_owned && !q_empty && mem_req_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_r    <= '0;
            wdata_r   <= '0;
            old_r     <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept) begin
                addr_r  <= req_addr;
                wdata_r <= req_wdata;
            end
            unique case (state)
                S_IDLE: begin
                    if (accept && op == OP_LOAD && q_hit) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= q_hit_data;
                    end
                    if (accept && op == OP_FENCE) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= '0;
                    end
                end
                S_LD_WAIT: if (mem_rsp_valid) begin
                    rsp_valid <= 1'b1;
                    rsp_rdata <= mem_rsp_rdata;
                end
                S_SW_WAIT: if (mem_rsp_valid) old_r <= mem_rsp_rdata;
                S_SW_WRITE: if (mem_req_ready) begin
                    rsp_valid <= 1'b1;
                    rsp_rdata <= old_r;
                end
                default: ;
            endcase
        end
    end

    // R6
    fence_drained_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_FENCE) |=> (rsp_valid && q_empty));

    // R7
    swap_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_SW_READ || state == S_SW_WAIT || state == S_SW_WRITE)
            |-> (q_empty && !q_pop));

    // R4
    miss_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_LD_WAIT && mem_req_valid) |-> mem_req_write);

    // R10
    store_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && accept && op == OP_STORE) |=> !rsp_valid);

    // R9
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state == S_IDLE && !rsp_valid));
endmodule

// File: rtl/tso_store_queue.sv
module tso_store_queue #(
    parameter int DEPTH = 8,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_rdata,
    output logic          sb_empty
);
    logic          q_push, q_pop, q_hit, q_full, q_empty;
    logic [DW-1:0] q_hit_data, head_data;
    logic [AW-1:0] head_addr;

    assign sb_empty = q_empty;

    tsq_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push      (q_push),
        .push_addr (req_addr),
        .push_data (req_wdata),
        .pop       (q_pop),
        .look_addr (req_addr),
        .hit       (q_hit),
        .hit_data  (q_hit_data),
        .head_addr (head_addr),
        .head_data (head_data),
        .full      (q_full),
        .empty     (q_empty)
    );

    tsq_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_op        (req_op),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .req_ready     (req_ready),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .q_empty       (q_empty),
        .q_full        (q_full),
        .q_hit         (q_hit),
        .q_hit_data    (q_hit_data),
        .head_addr     (head_addr),
        .head_data     (head_data),
        .q_push        (q_push),
        .q_pop         (q_pop),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata)
    );
endmodule

// File: tb/tb_tso_store_queue.sv
module tb_tso_store_queue;
    localparam int DEPTH = 8;
    localparam int AW    = 8;
    localparam int DW    = 32;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          mem_req_valid, mem_req_ready, mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_rdata = '0;
    logic          sb_empty;
    logic          wr_allow = 1'b0;

    logic [DW-1:0] mem [WORDS];
    logic [DW-1:0] ref_m [WORDS];
    logic [AW-1:0] ow_a [16];
    logic [DW-1:0] ow_d [16];
    int            ow_h = 0, ow_t = 0;
    int            checks = 0, errors = 0, mon_checks = 0, mon_errors = 0;

    always #5 clk = ~clk;

    assign mem_req_ready = !mem_req_write || wr_allow;

    tso_store_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .sb_empty(sb_empty)
    );

    initial begin
        for (int a = 0; a < WORDS; a++) mem[a] = 32'hC000_0000 | a;
    end

    // Memory model with one-cycle read latency, plus the R2 order monitor.
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (!rst && mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                mem[mem_req_addr] <= mem_req_wdata;
                if (ow_h != ow_t) begin
                    mon_checks++;
                    if (mem_req_addr != ow_a[ow_h % 16] || mem_req_wdata != ow_d[ow_h % 16]) begin
                        mon_errors++;
                        $display("FAIL R2 write order: got %h<=%h expected %h<=%h",
                                 mem_req_addr, mem_req_wdata, ow_a[ow_h % 16], ow_d[ow_h % 16]);
                    end
                    ow_h++;
                end
            end else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= mem[mem_req_addr];
            end
        end
        if (!rst && req_valid && req_ready && req_op == 2'd1) begin
            ow_a[ow_t % 16] = req_addr;
            ow_d[ow_t % 16] = req_wdata;
            ow_t++;
        end
    end

    task automatic check(input logic ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int waited;
        waited = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        #1;
        while (!req_ready) begin
            waited++;
            if (waited > 3) wr_allow = 1'b1;
            @(negedge clk); #1;
        end
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic get_rsp(input string req, output logic [DW-1:0] v);
        int n;
        n = 0;
        v = '0;
        forever begin
            @(negedge clk);
            if (rsp_valid) begin v = rsp_rdata; break; end
            n++;
            if (n > 100) begin check(1'b0, {req, " response timeout"}, '0, 1); break; end
        end
    endtask

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
        issue(2'd1, a, d);
        ref_m[a] = d;
    endtask

    task automatic do_load(input logic [AW-1:0] a, input string req);
        logic [DW-1:0] v;
        issue(2'd0, a, '0);
        get_rsp(req, v);
        check(v == ref_m[a], req, v, ref_m[a]);
    endtask

    task automatic do_fence(input string req);
        logic [DW-1:0] v;
        wr_allow = 1'b1;
        issue(2'd2, '0, '0);
        get_rsp(req, v);
        check(v == '0, req, v, '0);
    endtask

    task automatic do_swap(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
        logic [DW-1:0] v;
        logic [DW-1:0] exp;
        exp = ref_m[a];
        wr_allow = 1'b1;
        issue(2'd3, a, d);
        ref_m[a] = d;
        get_rsp(req, v);
        check(v == exp, req, v, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog: actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errors + mon_errors + 1);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        logic [15:0]   lfsr;
        int            mism;
        for (int a = 0; a < WORDS; a++) ref_m[a] = 32'hC000_0000 | a;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R9: reset state
        @(negedge clk);
        check(sb_empty && !mem_req_valid && !rsp_valid && req_ready, "R9 reset state",
              {sb_empty, mem_req_valid, rsp_valid, req_ready}, 4'b1001);

        // R1: store held in the queue while writes are refused
        wr_allow = 1'b0;
        do_store(8'h10, 32'h0000_0005);
        @(negedge clk);
        check(!sb_empty && mem[8'h10] == 32'hC000_0010, "R1 store queued, memory unchanged",
              mem[8'h10], 32'hC000_0010);
        check(mem_req_valid && mem_req_write && mem_req_addr == 8'h10, "R1 head presented",
              {mem_req_valid, mem_req_write}, 2'b11);

        // R3: youngest matching entry wins
        do_store(8'h10, 32'h0000_0006);
        do_store(8'h11, 32'h0000_0011);
        do_load(8'h10, "R3 youngest forward");
        check(mem[8'h10] == 32'hC000_0010, "R3 memory untouched by hit", mem[8'h10], 32'hC000_0010);

        // R4: miss passes queued stores
        issue(2'd0, 8'h20, '0);
        get_rsp("R4 miss", v);
        check(v == 32'hC000_0020, "R4 miss data", v, 32'hC000_0020);
        check(!sb_empty, "R4 stores still queued at miss response", sb_empty, 0);

        // R5: fill the queue, store held off, load still accepted
        for (int i = 0; i < 5; i++) do_store(AW'(8'h30 + i), 32'h300 + i);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd1; req_addr = 8'h40; req_wdata = 32'h40;
        #1 check(!req_ready, "R5 full blocks store", req_ready, 0);
        req_op = 2'd2;
        #1 check(!req_ready, "R6 fence blocked while queued", req_ready, 0);
        req_op = 2'd0;
        #1 check(req_ready, "R5 load accepted when full", req_ready, 1);
        req_valid = 1'b0;

        // R6: fence drains everything
        do_fence("R6 fence response");
        mism = 0;
        for (int a = 0; a < WORDS; a++) if (mem[a] != ref_m[a]) mism++;
        check(mism == 0 && sb_empty, "R6 memory complete at fence", mism, 0);

        // R7: swap drains then exchanges
        wr_allow = 1'b0;
        do_store(8'h50, 32'h0000_0001);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd3; req_addr = 8'h50;
        #1 check(!req_ready, "R7 swap blocked while queued", req_ready, 0);
        req_valid = 1'b0;
        do_swap(8'h50, 32'h0000_0009, "R7 swap old value");
        @(negedge clk);
        check(mem[8'h50] == 32'h9, "R7 swap new value in memory", mem[8'h50], 32'h9);
        do_load(8'h50, "R7 load after swap");

        // R8: load coinciding with retirement of its matching store
        wr_allow = 1'b1;
        do_store(8'h60, 32'h0000_0077);
        do_load(8'h60, "R8 load during retire");
        do_load(8'h60, "R8 load after retire");

        // R10: one response per fence back to back
        do_fence("R10 fence one");
        do_fence("R10 fence two");

        // Sweep over a small address set with random memory back-pressure
        lfsr = 16'hACE1;
        for (int n = 0; n < 800; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wr_allow = lfsr[3];
            case (lfsr[7:4])
                4'd0:        do_fence("R6 sweep fence");
                4'd1:        do_swap(AW'(lfsr[10:8]), {16'h5A00, lfsr}, "R7 sweep swap");
                4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7:
                             do_load(AW'(lfsr[10:8]), "R3 R4 sweep load");
                default:     do_store(AW'(lfsr[10:8]), {16'h0B00, lfsr});
            endcase
        end
        do_fence("R6 final fence");
        mism = 0;
        for (int a = 0; a < WORDS; a++) if (mem[a] != ref_m[a]) mism++;
        check(mism == 0, "R2 final memory image", mism, 0);
        check(ow_h == ow_t, "R2 all stores written", ow_h, ow_t);

        // R9: reset with entries queued
        wr_allow = 1'b0;
        do_store(8'h70, 32'h7);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        check(sb_empty && !mem_req_valid, "R9 reset discards entries", sb_empty, 1);

        $display("  CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errors);
        $finish;
    end
endmodule